// File: doc/BRIEF.md
# IDE Function Configuration Header

This block holds the 256-byte configuration space of an IDE controller function on a PCI bus. A bus-side front end, which is outside this block, decodes configuration cycles and presents each one as a single-cycle strobe. The strobe carries a start byte address, a length of 1 to 4 bytes and up to four data bytes. Reads are combinational and return the addressed bytes in little-endian order. Writes take effect at the clock edge that samples the strobe.

The space mixes several kinds of byte. Some carry fixed identification and class codes. The command byte has only two writable bits. Some bytes are locked, and whole address ranges drop any write that starts in them. Two bytes form the base of a 16-byte bus-master I/O window. The two drive-timing words take their reset value from drive-present inputs. The block exports the window base and a flag that says the base is non-zero. When a write changes the base it raises a one-cycle pulse, so that the I/O decoder can move the window.

Top module: `pide_cfg_hdr`

## Requirements
- R1: Bytes 0x00..0x03 always read 0x86, 0x80, 0x10, 0x70, and bytes 0x09..0x0B always read 0x80, 0x01, 0x01. Bytes 0x08 and 0x0E always read 0x00. Writes to any of these bytes have no effect.
- R2: After reset, byte 0x04 reads 0x01, 0x05 reads 0x00, 0x06 reads 0x80, 0x07 reads 0x02 and 0x44 reads 0x00. Every byte not named in R1, R5 or R7 reads 0x00.
- R3: In byte 0x04 only bits 0 and 2 take written data, and the other bits read 0. Bytes 0x05 and 0x06 ignore all writes.
- R4: A write whose start address lies in 0x10..0x1F or 0x22..0x3F changes no byte, even when its length reaches past the range. Bytes in those ranges always read 0x00.
- R5: Byte 0x20 resets to 0x01. A write to byte 0x20 stores bits 7..2 and forces bits 1..0 to binary 01. Byte 0x21 takes all eight written bits.
- R6: `bm_base_chg` is high for exactly the one cycle after a write that changes the stored value of byte 0x20 or 0x21. It stays low after writes that leave both bytes unchanged.
- R7: On reset, bytes 0x40/0x41 become 0x00/0x80 when `prim_present` is high, and 0x00/0x00 otherwise. Bytes 0x42/0x43 follow `sec_present` in the same way.
- R8: A read of length 1..4 returns byte (addr+k) mod 256 in bits 8k+7..8k, with zeros above the requested length. A write of length 1..4 stores data bits 8k+7..8k into byte (addr+k) mod 256, subject to that byte's rules.
- R9: A read with length 5..7 returns 0xFFFFFFFF, and a read with length 0 returns 0. Writes with length 0 or 5..7 change nothing.
- R10: `bm_base` equals {byte 0x21, byte 0x20 bits 7..1, 0}. `bm_base_valid` is high exactly when `bm_base` is non-zero.
- R11: All other bytes (0x07, 0x0C, 0x0D, 0x0F, 0x40..0xFF) store all eight written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prim_present | input | 1 | Primary drive present; sampled during reset |
| sec_present | input | 1 | Secondary drive present; sampled during reset |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_addr | input | 8 | Start byte address |
| cfg_len | input | 3 | Access length in bytes |
| cfg_wdata | input | 32 | Write data, lowest byte goes to the start address |
| cfg_rdata | output | 32 | Read data for the current address and length |
| bm_base | output | 16 | Bus-master I/O window base |
| bm_base_valid | output | 1 | Base is non-zero |
| bm_base_chg | output | 1 | Base changed by the previous write |

## Verification
Several properties are checked on every cycle:
- Over-long reads return all ones.
- The first identification byte and the forced low bits of byte 0x20 read back correctly.
- A change pulse only follows a write.
- The window base never moves without a write, nor after a write that starts in a dropped range.

Some behaviours only the directed scenarios can show:
- The per-byte write masks.
- A multi-byte write that starts in a dropped range but reaches into the base bytes.
- Address wrap past 0xFF.
- A write to byte 0x20 whose change the forced bits hide.
- The two drive-present reset variants.

// File: rtl/pide_cfg_pkg.sv
package pide_cfg_pkg;

    typedef enum logic [2:0] {
        BK_FIXED,
        BK_CMD,
        BK_BASE_LO,
        BK_BASE_HI,
        BK_FREE
    } byte_kind_e;

    localparam int unsigned BASE_LO_ADDR = 32'h20;
    localparam int unsigned BASE_HI_ADDR = 32'h21;

    // Bytes that never take written data
    function automatic logic is_locked(input int unsigned a);
        return (a <= 3) || (a >= 8 && a <= 11) || a == 5 || a == 6 || a == 14 ||
               (a >= 16 && a <= 31) || (a >= 34 && a <= 63);
    endfunction

    function automatic byte_kind_e kind_of(input int unsigned a);
        if (is_locked(a))        return BK_FIXED;
        if (a == 4)              return BK_CMD;
        if (a == BASE_LO_ADDR)   return BK_BASE_LO;
        if (a == BASE_HI_ADDR)   return BK_BASE_HI;
        return BK_FREE;
    endfunction

    // Reset / constant value of every byte
    function automatic logic [7:0] init_val(input int unsigned a, input logic prim, input logic sec);
        case (a)
            0:       return 8'h86;
            1:       return 8'h80;
            2:       return 8'h10;
            3:       return 8'h70;
            4:       return 8'h01;
            6:       return 8'h80;
            7:       return 8'h02;
            9:       return 8'h80;
            10:      return 8'h01;
            11:      return 8'h01;
            32:      return 8'h01;
            65:      return prim ? 8'h80 : 8'h00;
            67:      return sec  ? 8'h80 : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    // Start addresses whose writes are discarded whole
    function automatic logic drop_start(input logic [7:0] a);
        return (a >= 8'h10 && a <= 8'h1F) || (a >= 8'h22 && a <= 8'h3F);
    endfunction

endpackage

// File: rtl/pide_wr_lanes.sv
module pide_wr_lanes
    import pide_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LEN_W  = 3
) (
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [LEN_W-1:0]            len,
    input  logic [LANES*8-1:0]          wdata,
    output logic [(1<<ADDR_W)-1:0]      byte_we,
    output logic [(1<<ADDR_W)-1:0][7:0] byte_wd
);
    localparam int unsigned SPACE  = 1 << ADDR_W;
    localparam int unsigned LANE_W = $clog2(LANES);

    logic accept;

    assign accept = wr && (len != '0) && (len <= LEN_W'(LANES)) && !drop_start(8'(addr));

    for (genvar j = 0; j < SPACE; j++) begin : g_lane
        logic [ADDR_W-1:0] ofs;
        assign ofs        = ADDR_W'(j) - addr;
        assign byte_we[j] = accept && (ofs < ADDR_W'(len));
        assign byte_wd[j] = wdata[{ofs[LANE_W-1:0], 3'b000} +: 8];
    end

endmodule

// File: rtl/pide_byte_reg.sv
module pide_byte_reg
    import pide_cfg_pkg::*;
#(
    parameter int unsigned BYTE_ADDR = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prim_present,
    input  logic       sec_present,
    input  logic       we,
    input  logic [7:0] wd,
    output logic [7:0] q
);
    localparam byte_kind_e KIND = kind_of(BYTE_ADDR);

    logic [7:0] q_r;
    logic [7:0] nxt;

    always_comb begin
        nxt = q_r;
        if (we) begin
            unique case (KIND)
                BK_FIXED:   nxt = q_r;
                BK_CMD:     nxt = wd & 8'h05;
                BK_BASE_LO: nxt = {wd[7:2], 2'b01};
                BK_BASE_HI: nxt = wd;
                BK_FREE:    nxt = wd;
                default:    nxt = q_r;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= init_val(BYTE_ADDR, prim_present, sec_present);
        else     q_r <= nxt;
    end

    assign q = q_r;

endmodule

// File: rtl/pide_rd_mux.sv
module pide_rd_mux #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LEN_W  = 3
) (
    input  logic [(1<<ADDR_W)-1:0][7:0] bytes_in,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [LEN_W-1:0]            len,
    output logic [LANES*8-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        if (len > LEN_W'(LANES)) begin
            rdata = '1;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (LEN_W'(k) < len)
                    rdata[k*8 +: 8] = bytes_in[addr + ADDR_W'(k)];
            end
        end
    end

endmodule

// File: rtl/pide_cfg_hdr.sv
module pide_cfg_hdr
    import pide_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LEN_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prim_present,
    input  logic                sec_present,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [LANES*8-1:0]  cfg_wdata,
    output logic [LANES*8-1:0]  cfg_rdata,
    output logic [15:0]         bm_base,
    output logic                bm_base_valid,
    output logic                bm_base_chg
);
    localparam int unsigned SPACE = 1 << ADDR_W;

    logic [SPACE-1:0]      byte_we;
    logic [SPACE-1:0][7:0] byte_wd;
    logic [SPACE-1:0][7:0] cfg_bytes;
    logic [15:0]           base_raw;
    logic [15:0]           prev_base_r;

    pide_wr_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) u_lanes (
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .len     (cfg_len),
        .wdata   (cfg_wdata),
        .byte_we (byte_we),
        .byte_wd (byte_wd)
    );

    for (genvar j = 0; j < SPACE; j++) begin : g_byte
        pide_byte_reg #(.BYTE_ADDR(j)) u_reg (
            .clk          (clk),
            .rst          (rst),
            .prim_present (prim_present),
            .sec_present  (sec_present),
            .we           (byte_we[j]),
            .wd           (byte_wd[j]),
            .q            (cfg_bytes[j])
        );
    end

    pide_rd_mux #(.ADDR_W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) u_rd (
        .bytes_in (cfg_bytes),
        .addr     (cfg_addr),
        .len      (cfg_len),
        .rdata    (cfg_rdata)
    );

    assign base_raw = {cfg_bytes[BASE_HI_ADDR], cfg_bytes[BASE_LO_ADDR]};

    // Previous base value; a mismatch marks the cycle after a changing write
    always_ff @(posedge clk) begin
        if (rst) prev_base_r <= {init_val(BASE_HI_ADDR, 1'b0, 1'b0), init_val(BASE_LO_ADDR, 1'b0, 1'b0)};
        else     prev_base_r <= base_raw;
    end

    assign bm_base       = {base_raw[15:1], 1'b0};
    assign bm_base_valid = |bm_base;
    assign bm_base_chg   = (base_raw != prev_base_r);

endmodule

// File: rtl/pide_cfg_checker.sv
module pide_cfg_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LEN_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_wr,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [LEN_W-1:0]   cfg_len,
    input logic [LANES*8-1:0] cfg_rdata,
    input logic [15:0]        bm_base,
    input logic               bm_base_chg
);
    a_r1_id_byte: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == ADDR_W'(0) && cfg_len == LEN_W'(1)) |-> (cfg_rdata == 32'h0000_0086));

    a_r9_long_read: assert property (@(posedge clk) disable iff (rst)
        (cfg_len > LEN_W'(LANES)) |-> (cfg_rdata == '1));

    a_r5_base_low_bits: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == ADDR_W'(32) && cfg_len == LEN_W'(1)) |-> (cfg_rdata[1:0] == 2'b01));

    a_r6_chg_after_write: assert property (@(posedge clk) disable iff (rst)
        bm_base_chg |-> $past(cfg_wr));

    a_r10_base_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_wr) |-> $stable(bm_base));

    a_r4_drop_keeps_base: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr) &&
         (($past(cfg_addr) >= ADDR_W'(16) && $past(cfg_addr) <= ADDR_W'(31)) ||
          ($past(cfg_addr) >= ADDR_W'(34) && $past(cfg_addr) <= ADDR_W'(63))))
        |-> ($stable(bm_base) && !bm_base_chg));

endmodule

bind pide_cfg_hdr pide_cfg_checker #(.ADDR_W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_len     (cfg_len),
    .cfg_rdata   (cfg_rdata),
    .bm_base     (bm_base),
    .bm_base_chg (bm_base_chg)
);

// File: tb/pide_cfg_hdr_bench.sv
module pide_cfg_hdr_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prim_present = 1'b1;
    logic        sec_present  = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [2:0]  cfg_len = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] bm_base;
    logic        bm_base_valid;
    logic        bm_base_chg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pide_cfg_hdr u_pide_cfg_hdr (
        .clk           (clk),
        .rst           (rst),
        .prim_present  (prim_present),
        .sec_present   (sec_present),
        .cfg_wr        (cfg_wr),
        .cfg_addr      (cfg_addr),
        .cfg_len       (cfg_len),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .bm_base       (bm_base),
        .bm_base_valid (bm_base_valid),
        .bm_base_chg   (bm_base_chg)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns the change pulse seen one cycle later
    task automatic do_wr(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d,
                         output logic chg);
        cfg_wr = 1'b1; cfg_addr = a; cfg_len = l; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        chg = bm_base_chg;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [2:0] l, output logic [31:0] v);
        cfg_addr = a; cfg_len = l;
        #2;
        v = cfg_rdata;
        @(negedge clk);
    endtask

    task automatic apply_reset(input logic p, input logic s);
        @(negedge clk);
        prim_present = p; sec_present = s; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_values;
        logic [31:0] v;
        do_rd(8'h00, 3'd4, v); check("R1 id bytes", v, 32'h7010_8086);
        do_rd(8'h08, 3'd4, v); check("R1 class bytes", v, 32'h0101_8000);
        do_rd(8'h04, 3'd4, v); check("R2 cmd/status reset", v, 32'h0280_0001);
        do_rd(8'h0C, 3'd4, v); check("R2 header type zero", v, 32'h0);
        do_rd(8'h20, 3'd2, v); check("R5 base reset", v, 32'h0001);
        do_rd(8'h44, 3'd1, v); check("R2 byte 0x44 reset", v, 32'h0);
        do_rd(8'h40, 3'd4, v); check("R7 primary present timing", v, 32'h0000_8000);
        check("R10 base after reset", {16'h0, bm_base}, 32'h0);
        check("R10 valid after reset", {31'h0, bm_base_valid}, 32'h0);
        check("R6 no pulse after reset", {31'h0, bm_base_chg}, 32'h0);
    endtask

    task automatic t_fixed_bytes;
        logic [31:0] v; logic c;
        do_wr(8'h00, 3'd4, 32'hFFFF_FFFF, c);
        do_rd(8'h00, 3'd4, v); check("R1 id ignores write", v, 32'h7010_8086);
        do_wr(8'h08, 3'd4, 32'hFFFF_FFFF, c);
        do_rd(8'h08, 3'd4, v); check("R1 class ignores write", v, 32'h0101_8000);
        do_wr(8'h0C, 3'd4, 32'hA5A5_A5A5, c);
        do_rd(8'h0C, 3'd4, v); check("R11 byte 0x0E locked, neighbours free", v, 32'hA500_A5A5);
    endtask

    task automatic t_command_mask;
        logic [31:0] v; logic c;
        do_wr(8'h04, 3'd4, 32'hFFFF_FFFF, c);
        do_rd(8'h04, 3'd4, v); check("R3 cmd mask, 0x05/0x06 locked, R11 0x07 free", v, 32'hFF80_0005);
        do_wr(8'h04, 3'd1, 32'h0000_00FA, c);
        do_rd(8'h04, 3'd1, v); check("R3 cmd cleared", v, 32'h0);
    endtask

    task automatic t_base_register;
        logic [31:0] v; logic c;
        do_wr(8'h20, 3'd2, 32'h0000_1234, c);
        check("R6 pulse on base change", {31'h0, c}, 32'h1);
        do_rd(8'h20, 3'd2, v); check("R5 low bits forced", v, 32'h0000_1235);
        check("R6 pulse lasts one cycle", {31'h0, bm_base_chg}, 32'h0);
        check("R10 base value", {16'h0, bm_base}, 32'h0000_1234);
        check("R10 valid", {31'h0, bm_base_valid}, 32'h1);
        do_wr(8'h21, 3'd1, 32'h0000_0012, c);
        check("R6 no pulse on same value", {31'h0, c}, 32'h0);
        do_wr(8'h20, 3'd1, 32'h0000_0036, c);
        check("R6 no pulse when forced bits hide change", {31'h0, c}, 32'h0);
        do_wr(8'h20, 3'd1, 32'h0000_003B, c);
        check("R6 pulse on low byte change", {31'h0, c}, 32'h1);
        check("R10 base updated", {16'h0, bm_base}, 32'h0000_1238);
    endtask

    task automatic t_dropped_ranges;
        logic [31:0] v; logic c;
        do_wr(8'h1E, 3'd4, 32'hAABB_CCDD, c);
        check("R4 spill into base dropped, no pulse", {31'h0, c}, 32'h0);
        do_rd(8'h20, 3'd2, v); check("R4 base bytes unchanged", v, 32'h0000_1239);
        do_wr(8'h3E, 3'd4, 32'h1122_3344, c);
        do_rd(8'h40, 3'd2, v); check("R4 spill into timing dropped", v, 32'h0000_8000);
        do_wr(8'h0F, 3'd4, 32'h5566_7788, c);
        do_rd(8'h10, 3'd4, v); check("R4 range bytes read zero", v, 32'h0);
        do_rd(8'h0F, 3'd1, v); check("R11 byte 0x0F stored", v, 32'h0000_0088);
        do_wr(8'h22, 3'd1, 32'h0000_00FF, c);
        do_rd(8'h22, 3'd1, v); check("R4 byte 0x22 stays zero", v, 32'h0);
    endtask

    task automatic t_ordering_and_wrap;
        logic [31:0] v; logic c;
        do_wr(8'h44, 3'd4, 32'hDEAD_BEEF, c);
        do_rd(8'h44, 3'd4, v); check("R8 four byte round trip", v, 32'hDEAD_BEEF);
        do_rd(8'h45, 3'd2, v); check("R8 little-endian partial read", v, 32'h0000_ADBE);
        do_wr(8'hFE, 3'd4, 32'h1122_3344, c);
        do_rd(8'hFE, 3'd2, v); check("R8 write wrap low bytes", v, 32'h0000_3344);
        do_rd(8'hFF, 3'd3, v); check("R8 read wrap into id", v, 32'h0080_8633);
    endtask

    task automatic t_length_limits;
        logic [31:0] v; logic c;
        do_rd(8'h00, 3'd5, v); check("R9 length 5 read", v, 32'hFFFF_FFFF);
        do_rd(8'h44, 3'd7, v); check("R9 length 7 read", v, 32'hFFFF_FFFF);
        do_rd(8'h44, 3'd0, v); check("R9 length 0 read", v, 32'h0);
        do_wr(8'h44, 3'd5, 32'h0, c);
        do_wr(8'h44, 3'd0, 32'h0, c);
        do_rd(8'h44, 3'd4, v); check("R9 bad length writes ignored", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_secondary_reset;
        logic [31:0] v;
        apply_reset(1'b0, 1'b1);
        do_rd(8'h40, 3'd4, v); check("R7 secondary present timing", v, 32'h8000_0000);
        do_rd(8'h44, 3'd4, v); check("R2 byte 0x44 cleared again", v, 32'h0);
        check("R10 base back to zero", {15'h0, bm_base_valid, bm_base}, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        apply_reset(1'b1, 1'b0);
        t_reset_values();
        t_fixed_bytes();
        t_command_mask();
        t_base_register();
        t_dropped_ranges();
        t_ordering_and_wrap();
        t_length_limits();
        t_secondary_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule